// File: doc/BRIEF.md
# Dual Programmable Sample-Rate Pacer

This block paces four converter channels (ADC left, ADC right, DAC left, DAC right) on a serial audio/modem link whose frame rate is fixed at 48 kHz. It holds two rate generators. Each one stores a sample rate in whole hertz and, on every frame tick, decides whether a sample falls due in that frame. The two generators run independently. Each channel is routed to one of them by a control bit.

The second generator can have its rate scaled by a fixed 8/7 or 10/7 factor, which gives the irrational rates that modems use. The first generator is never scaled. The per-frame results appear on plain level outputs: a request flag for each DAC channel and a valid flag for each ADC channel. The two DAC flags can also be read back through a small register port.

The block moves no sample data. It therefore has no valid/ready stream interface, and every pin is a plain control or status signal. Register reads are combinational from `reg_addr`. A write takes effect at the clock edge where `reg_wr` is high.

Top module: `dual_srate_gen`

## Requirements
- R1: After reset:
  - both rate registers (address 78h for generator 0, 7Ah for generator 1) read 48000 (BB80h);
  - registers 76h and 74h read 0;
  - all four channel outputs are low.
- R2: An unscaled generator with rate F (7000..48000), started from a clean phase, signals a sample in exactly floor(N·F/48000) of the next N frame ticks.
- R3: At 48000 Hz a sample is due on every frame. The channel outputs change only in the cycle after a clock edge where `frame_tick` is high, and they hold between ticks.
- R4: Register 76h routes each channel to a generator: bit 0 for ADC right, bit 2 for DAC right, bit 8 for ADC left and bit 10 for DAC left. A 0 selects generator 0 and a 1 selects generator 1.
- R5: Bit 5 of 76h scales generator 1's rate by 8/7, and bit 6 scales it by 10/7. Generator 0 is unaffected by either bit.
- R6: When bits 5 and 6 of 76h are both set, generator 1 runs unscaled.
- R7: The effective rate, after any scaling, is clamped into 7000..48000 Hz. The rate registers read back the raw value that was written.
- R8: Writing a generator's rate register, or writing 76h with a change in bits 5 or 6 (generator 1 only), restarts that generator from a clean phase. If such a write falls on a clock edge that also carries a frame tick, the write wins: no sample is due for that frame.
- R9: Register 74h is read-only. Bit 0 shows the DAC right request, bit 8 shows the DAC left request, and all other bits read 0. Writes to 74h have no effect.
- R10: Bits of 76h other than 0, 2, 5, 6, 8 and 10 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle pulse per 48 kHz frame |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| adc_l_valid | output | 1 | ADC left sample due this frame |
| adc_r_valid | output | 1 | ADC right sample due this frame |
| dac_l_req | output | 1 | DAC left request for this frame |
| dac_r_req | output | 1 | DAC right request for this frame |

## Verification
A rate-register write and a frame tick can reach the same generator on the same clock edge. In that case the restart and the phase advance compete.

The bench first advances generator 0 at 24000 Hz by one tick, which leaves the phase at half of a sample period. It then drives a rewrite of the same rate in the same cycle as the next tick. With the restart winning, that frame carries no request and the next request appears two ticks later. If the tick won, the request would appear at once, so the test separates the two orderings by the request pattern alone.

// File: rtl/srg_pkg.sv
package srg_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] A_REQ   = 7'h74;
  localparam logic [ADDR_W-1:0] A_ROUTE = 7'h76;
  localparam logic [ADDR_W-1:0] A_RATE0 = 7'h78;
  localparam logic [ADDR_W-1:0] A_RATE1 = 7'h7A;

  localparam int B_ADC_R = 0;
  localparam int B_DAC_R = 2;
  localparam int B_X8    = 5;
  localparam int B_X10   = 6;
  localparam int B_ADC_L = 8;
  localparam int B_DAC_L = 10;

  localparam logic [DATA_W-1:0] ROUTE_MASK =
    DATA_W'((1 << B_ADC_R) | (1 << B_DAC_R) | (1 << B_X8) |
            (1 << B_X10) | (1 << B_ADC_L) | (1 << B_DAC_L));

  typedef enum logic [1:0] {SC_NONE, SC_8D7, SC_10D7} scale_e;
endpackage

// File: rtl/srg_phase_acc.sv
module srg_phase_acc
  import srg_pkg::*;
#(
  parameter int RATE_W   = 16,
  parameter int FRAME_HZ = 48000,
  parameter int MIN_HZ   = 7000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              clr,
  input  logic [RATE_W-1:0] rate,
  input  scale_e            scale,
  output logic              due
);
  // common denominator of 7 keeps every mode on one threshold
  localparam int DEN   = 7;
  localparam int THR   = FRAME_HZ * DEN;
  localparam int LO    = MIN_HZ * DEN;
  localparam int ACC_W = $clog2((2 ** RATE_W) * 10);

  localparam logic [ACC_W-1:0] THR_V = ACC_W'(THR);
  localparam logic [ACC_W-1:0] LO_V  = ACC_W'(LO);

  logic [ACC_W-1:0] rate_x, raw, inc, acc_q;
  logic [ACC_W:0]   sum;
  logic             due_q;

  assign rate_x = {{(ACC_W-RATE_W){1'b0}}, rate};

  always_comb begin
    unique case (scale)
      SC_8D7:  raw = rate_x << 3;
      SC_10D7: raw = (rate_x << 3) + (rate_x << 1);
      default: raw = (rate_x << 3) - rate_x;
    endcase
    if (raw < LO_V)       inc = LO_V;
    else if (raw > THR_V) inc = THR_V;
    else                  inc = raw;
  end

  assign sum = {1'b0, acc_q} + {1'b0, inc};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      due_q <= 1'b0;
    end else if (clr) begin
      acc_q <= '0;
      if (tick) due_q <= 1'b0;
    end else if (tick) begin
      if (sum >= {1'b0, THR_V}) begin
        acc_q <= ACC_W'(sum - {1'b0, THR_V});
        due_q <= 1'b1;
      end else begin
        acc_q <= sum[ACC_W-1:0];
        due_q <= 1'b0;
      end
    end
  end

  assign due = due_q;

  // R7
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < THR_V);

  // R3
  due_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> $stable(due_q));

  // R8
  clr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == '0));
endmodule

// File: rtl/srg_regs.sv
module srg_regs
  import srg_pkg::*;
#(
  parameter int RATE_W   = 16,
  parameter int FRAME_HZ = 48000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              req_l,
  input  logic              req_r,
  output logic [DATA_W-1:0] rdata,
  output logic [RATE_W-1:0] rate0,
  output logic [RATE_W-1:0] rate1,
  output logic [3:0]        sel,
  output scale_e            scale1,
  output logic              clr0,
  output logic              clr1
);
  localparam logic [RATE_W-1:0] RST_RATE = RATE_W'(FRAME_HZ);

  logic [RATE_W-1:0] rate0_q, rate1_q;
  logic [DATA_W-1:0] ctl_q;
  logic wr_r0, wr_r1, wr_ctl;

  assign wr_r0  = wr && (addr == A_RATE0);
  assign wr_r1  = wr && (addr == A_RATE1);
  assign wr_ctl = wr && (addr == A_ROUTE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate0_q <= RST_RATE;
      rate1_q <= RST_RATE;
      ctl_q   <= '0;
    end else begin
      if (wr_r0)  rate0_q <= wdata[RATE_W-1:0];
      if (wr_r1)  rate1_q <= wdata[RATE_W-1:0];
      if (wr_ctl) ctl_q   <= wdata & ROUTE_MASK;
    end
  end

  assign clr0 = wr_r0;
  assign clr1 = wr_r1 ||
                (wr_ctl && (wdata[B_X10:B_X8] != ctl_q[B_X10:B_X8]));

  always_comb begin
    unique case (ctl_q[B_X10:B_X8])
      2'b01:   scale1 = SC_8D7;
      2'b10:   scale1 = SC_10D7;
      default: scale1 = SC_NONE;
    endcase
  end

  // sel order: {dac_l, adc_l, dac_r, adc_r}
  assign sel   = {ctl_q[B_DAC_L], ctl_q[B_ADC_L], ctl_q[B_DAC_R], ctl_q[B_ADC_R]};
  assign rate0 = rate0_q;
  assign rate1 = rate1_q;

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_REQ: begin
        rdata[0] = req_r;
        rdata[8] = req_l;
      end
      A_ROUTE: rdata = ctl_q;
      A_RATE0: rdata = DATA_W'(rate0_q);
      A_RATE1: rdata = DATA_W'(rate1_q);
      default: rdata = '0;
    endcase
  end

  // R7
  rate_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_r0 |=> (rate0_q == $past(wdata[RATE_W-1:0])));

  // R10
  route_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> ((ctl_q & ~ROUTE_MASK) == '0));
endmodule

// File: rtl/dual_srate_gen.sv
module dual_srate_gen
  import srg_pkg::*;
#(
  parameter int RATE_W   = 16,
  parameter int FRAME_HZ = 48000,
  parameter int MIN_HZ   = 7000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_tick,
  input  logic        reg_wr,
  input  logic [6:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        adc_l_valid,
  output logic        adc_r_valid,
  output logic        dac_l_req,
  output logic        dac_r_req
);
  localparam int NGEN = 2;
  localparam int NCH  = 4;

  logic [RATE_W-1:0] rate   [NGEN];
  scale_e            scale  [NGEN];
  logic [NGEN-1:0]   clr, due;
  logic [NCH-1:0]    sel, ch_due;
  scale_e            scale1;

  srg_regs #(.RATE_W(RATE_W), .FRAME_HZ(FRAME_HZ)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .req_l(dac_l_req), .req_r(dac_r_req),
    .rdata(reg_rdata), .rate0(rate[0]), .rate1(rate[1]), .sel(sel),
    .scale1(scale1), .clr0(clr[0]), .clr1(clr[1])
  );

  assign scale[0] = SC_NONE;
  assign scale[1] = scale1;

  for (genvar g = 0; g < NGEN; g++) begin : g_gen
    srg_phase_acc #(.RATE_W(RATE_W), .FRAME_HZ(FRAME_HZ), .MIN_HZ(MIN_HZ)) u_acc (
      .clk(clk), .rst_n(rst_n), .tick(frame_tick), .clr(clr[g]),
      .rate(rate[g]), .scale(scale[g]), .due(due[g])
    );
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ch_due[c] = due[sel[c]];
  end

  assign adc_r_valid = ch_due[0];
  assign dac_r_req   = ch_due[1];
  assign adc_l_valid = ch_due[2];
  assign dac_l_req   = ch_due[3];

  // R4
  same_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel[3] == sel[1]) |-> (dac_l_req == dac_r_req));
endmodule

// File: tb/sim_dual_srate_gen.sv
module sim_dual_srate_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_tick = 1'b0;
  logic        reg_wr = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        adc_l_valid, adc_r_valid, dac_l_req, dac_r_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_srate_gen u0 (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .adc_l_valid(adc_l_valid), .adc_r_valid(adc_r_valid),
    .dac_l_req(dac_l_req), .dac_r_req(dac_r_req)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output int v);
    @(negedge clk);
    reg_addr = a;
    #1 v = int'(reg_rdata);
  endtask

  task automatic tick();
    @(negedge clk);
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
  endtask

  // counts per channel over n ticks: {dac_l, adc_l, dac_r, adc_r}
  task automatic run(input int n, output int cdl, output int cal, output int cdr, output int car);
    cdl = 0; cal = 0; cdr = 0; car = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      cdl += int'(dac_l_req); cal += int'(adc_l_valid);
      cdr += int'(dac_r_req); car += int'(adc_r_valid);
    end
  endtask

  task automatic t_reset();
    int v;
    rd(7'h78, v); check(v == 48000, "R1 rate0", v, 48000);
    rd(7'h7A, v); check(v == 48000, "R1 rate1", v, 48000);
    rd(7'h76, v); check(v == 0, "R1 route", v, 0);
    rd(7'h74, v); check(v == 0, "R1 req", v, 0);
    v = int'({dac_l_req, adc_l_valid, dac_r_req, adc_r_valid});
    check(v == 0, "R1 outputs", v, 0);
  endtask

  task automatic t_full_rate();
    int a, b, c, d;
    run(3, a, b, c, d);
    check(c == 3 && a == 3 && b == 3 && d == 3, "R3 every frame", c, 3);
    repeat (5) @(negedge clk);
    check(dac_r_req == 1'b1, "R3 hold between ticks", int'(dac_r_req), 1);
  endtask

  task automatic t_rates();
    int a, b, c, d;
    wr(7'h78, 16'd12000);
    run(48, a, b, c, d);
    check(c == 12, "R2 12000 Hz", c, 12);
    wr(7'h78, 16'd7000);
    run(48, a, b, c, d);
    check(c == 7, "R2 7000 Hz", c, 7);
  endtask

  task automatic t_route();
    int a, b, c, d, v;
    wr(7'h78, 16'd12000);
    wr(7'h76, 16'h0500);
    run(1, a, b, c, d);
    rd(7'h74, v); check(v == 16'h0100, "R9 left only", v, 16'h0100);
    run(3, a, b, c, d);
    rd(7'h74, v); check(v == 16'h0101, "R9 both", v, 16'h0101);
    wr(7'h78, 16'd12000);
    run(4, a, b, c, d);
    check(a == 4 && b == 4, "R4 left on gen1", a, 4);
    check(c == 1 && d == 1, "R4 right on gen0", c, 1);
    wr(7'h76, 16'h0005);
    wr(7'h78, 16'd12000);
    run(4, a, b, c, d);
    check(c == 4 && d == 4 && a == 1 && b == 1, "R4 swapped", c, 4);
  endtask

  task automatic t_scale();
    int a, b, c, d;
    wr(7'h76, 16'h0440);
    wr(7'h7A, 16'd16000);
    wr(7'h78, 16'd12000);
    run(21, a, b, c, d);
    check(a == 10, "R5 10/7 count", a, 10);
    check(c == 5, "R5 gen0 unscaled", c, 5);
    wr(7'h76, 16'h0420);
    wr(7'h7A, 16'd21000);
    run(20, a, b, c, d);
    check(a == 10, "R5 8/7 count", a, 10);
    wr(7'h76, 16'h0460);
    wr(7'h7A, 16'd12000);
    run(20, a, b, c, d);
    check(a == 5, "R6 both bits unscaled", a, 5);
  endtask

  task automatic t_clamp();
    int a, b, c, d, v;
    wr(7'h76, 16'h0000);
    wr(7'h78, 16'd60000);
    run(10, a, b, c, d);
    check(c == 10, "R7 high clamp", c, 10);
    wr(7'h78, 16'd1000);
    run(48, a, b, c, d);
    check(c == 7, "R7 low clamp", c, 7);
    rd(7'h78, v); check(v == 1000, "R7 raw readback", v, 1000);
    wr(7'h76, 16'h0440);
    wr(7'h7A, 16'd45000);
    run(10, a, b, c, d);
    check(a == 10, "R7 scaled high clamp", a, 10);
    wr(7'h76, 16'h0420);
    wr(7'h7A, 16'd2000);
    run(48, a, b, c, d);
    check(a == 7, "R7 scaled low clamp", a, 7);
  endtask

  task automatic t_readonly();
    int v;
    wr(7'h76, 16'h0000);
    wr(7'h78, 16'd48000);
    tick();
    wr(7'h74, 16'hFFFF);
    rd(7'h74, v); check(v == 16'h0101, "R9 write ignored", v, 16'h0101);
    wr(7'h76, 16'hFFFF);
    rd(7'h76, v); check(v == 16'h0565, "R10 reserved zero", v, 16'h0565);
    wr(7'h76, 16'h0000);
  endtask

  task automatic t_collide();
    wr(7'h78, 16'd24000);
    tick();
    check(dac_r_req == 1'b0, "R8 first tick", int'(dac_r_req), 0);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 7'h78; reg_wdata = 16'd24000; frame_tick = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; frame_tick = 1'b0;
    check(dac_r_req == 1'b0, "R8 write wins", int'(dac_r_req), 0);
    tick();
    check(dac_r_req == 1'b0, "R8 clean phase", int'(dac_r_req), 0);
    tick();
    check(dac_r_req == 1'b1, "R8 due after restart", int'(dac_r_req), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_full_rate();
    t_rates();
    t_route();
    t_scale();
    t_clamp();
    t_readonly();
    t_collide();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule